// File: doc/BRIEF.md
# Message DMA Engine for a Shared Address/Data Bus

This engine sits between a processor's private scratch-pad memory and an on-chip bus whose lines carry either an address word or a data word. The processor sets it up through a small register file. It can run one outgoing burst at a time. The burst reads a run of words from local memory and sends them behind a single bus address word. Each burst is described by a local source address, a bus target address, a word count and a command write that starts it.

On the receive side, several channels can be armed at the same time. Each channel holds a bus address to match, a local buffer base and a word count. An incoming address word selects the lowest-numbered enabled channel whose match address equals it. The data words that follow land in that channel's buffer, and each channel's write pointer resumes where it stopped, so bursts to different channels may interleave. When a channel has received its full count, it sets its done bit and disarms itself. Software can poll done, or let it drive the interrupt line through a per-channel enable.

The local memory port makes one access per cycle and reads without latency. A receive write takes the port first, and a transmit read waits for the next free cycle.

Top module: `msg_dma_engine`

## Requirements
- R1: After reset, `tx_valid`, `irq` and `mem_en` are 0, and the control/status word (register 3) reads 0.
- R2: Registers 0, 1 and 2 hold the local source, the bus target and the word count. Writing bit 0 of register 3 starts a burst. The burst first emits one word with `tx_is_addr`=1 carrying the target. It then emits count words with `tx_is_addr`=0, read from local addresses source, source+1, and so on in order. A word moves on a cycle where `tx_valid` and `tx_ready` are both 1.
- R3: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_is_addr` keep their values into the next cycle.
- R4: A start while a burst runs (status bit 0 = busy) is refused. It sets the sticky error bit (status bit 1), and the running burst finishes unchanged. Writing 1 to bit 1 of register 3 clears the error bit.
- R5: A start with a count of 0 sets the error bit, leaves busy at 0 and produces no bus word.
- R6: Channel k occupies registers 8+4k to 11+4k: match address, local base, word count, control. In the control register, bit 0 is enable, bit 1 is interrupt enable and bit 2 is done. Writing control with bit 0 set arms the channel and rewinds its pointer. Data after a matching address word is written to base+pointer, and the pointer advances by one per word. A channel's pointer is kept across interleaved bursts to other channels.
- R7: When a channel has stored count words, its done bit becomes 1 and its enable becomes 0. Any further data in that burst is not written.
- R8: An address word that matches no enabled channel sets the sticky unmatched bit (status bit 2). The data words after it are not written. Writing 1 to bit 2 of register 3 clears the bit.
- R9: `irq` is 1 exactly when some channel has both done and interrupt enable set. Writing control with bit 2 set clears done.
- R10: A receive write and a transmit read that fall in the same cycle are served one after the other, receive first. Both streams complete with correct data.
- R11: When two enabled channels share a match address, the lower-numbered channel takes the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| tx_valid | output | 1 | Outgoing bus word valid |
| tx_is_addr | output | 1 | Outgoing word is an address word |
| tx_data | output | 32 | Outgoing bus word |
| tx_ready | input | 1 | Bus accepts the outgoing word |
| rx_valid | input | 1 | Incoming bus word valid |
| rx_is_addr | input | 1 | Incoming word is an address word |
| rx_data | input | 32 | Incoming bus word |
| mem_en | output | 1 | Local memory access this cycle |
| mem_we | output | 1 | Local memory write |
| mem_addr | output | 8 | Local memory word address |
| mem_wdata | output | 32 | Local memory write data |
| mem_rdata | input | 32 | Local memory read data, same cycle |
| irq | output | 1 | Interrupt to the local processor |

## Verification
The two functions that can meet in one cycle are a receive write and a transmit read on the single local memory port. The bench arms a channel for six words and starts a six-word burst. It then feeds an address word and six back-to-back data words, timed so that every data beat coincides with a cycle in which the transmitter wants to read. The transmitter's stream is judged word by word against the source pattern, and the receive buffer against the injected data. A dropped, duplicated or stale word on either side shows up as a mismatch. The stall-hold and busy-refusal properties run over the same traffic.

// File: rtl/msg_dma_pkg.sv
package msg_dma_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_ADDR, TX_DATA} tx_state_e;
  localparam int unsigned REG_SRC = 0;
  localparam int unsigned REG_DST = 1;
  localparam int unsigned REG_AMT = 2;
  localparam int unsigned REG_CTL = 3;
  localparam int unsigned CH_BASE = 8;
endpackage

// File: rtl/msg_dma_tx.sv
module msg_dma_tx
  import msg_dma_pkg::*;
#(
  parameter int DW  = 32,
  parameter int LAW = 8,
  parameter int CW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           err_clr,
  input  logic [LAW-1:0] cfg_src,
  input  logic [DW-1:0]  cfg_dst,
  input  logic [CW-1:0]  cfg_amt,
  input  logic           mem_gnt,
  input  logic [DW-1:0]  mem_rdata,
  output logic           rd_req,
  output logic [LAW-1:0] rd_addr,
  output logic           tx_valid,
  output logic           tx_is_addr,
  output logic [DW-1:0]  tx_data,
  input  logic           tx_ready,
  output logic           busy,
  output logic           err
);
  tx_state_e      st_q, st_d;
  logic [CW-1:0]  ptr_q, ptr_d, amt_q;
  logic [LAW-1:0] src_q;
  logic [DW-1:0]  dst_q, od_q, od_d;
  logic           ov_q, ov_d, oa_q, oa_d, err_q, err_d;
  logic           accept, can_load, more;

  assign can_load = !ov_q || tx_ready;
  assign more     = (ptr_q != amt_q);
  assign rd_req   = (st_q == TX_DATA) && can_load && more;
  assign rd_addr  = src_q + LAW'(ptr_q);

  always_comb begin
    st_d = st_q; ptr_d = ptr_q; ov_d = ov_q; oa_d = oa_q; od_d = od_q;
    err_d = err_q; accept = 1'b0;
    if (err_clr) err_d = 1'b0;
    unique case (st_q)
      TX_IDLE: begin
        if (start) begin
          if (cfg_amt == '0) err_d = 1'b1;
          else begin
            accept = 1'b1;
            st_d   = TX_ADDR;
            ptr_d  = '0;
          end
        end
      end
      TX_ADDR: begin
        if (start) err_d = 1'b1;
        if (can_load) begin
          ov_d = 1'b1; oa_d = 1'b1; od_d = dst_q; st_d = TX_DATA;
        end
      end
      default: begin
        if (start) err_d = 1'b1;
        if (can_load) begin
          if (more && mem_gnt) begin
            ov_d = 1'b1; oa_d = 1'b0; od_d = mem_rdata; ptr_d = ptr_q + CW'(1);
          end else begin
            ov_d = 1'b0;
            if (!more) st_d = TX_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TX_IDLE; ptr_q <= '0; ov_q <= 1'b0; oa_q <= 1'b0; od_q <= '0;
      err_q <= 1'b0; src_q <= '0; dst_q <= '0; amt_q <= '0;
    end else begin
      st_q <= st_d; ptr_q <= ptr_d; ov_q <= ov_d; oa_q <= oa_d; od_q <= od_d;
      err_q <= err_d;
      if (accept) begin
        src_q <= cfg_src; dst_q <= cfg_dst; amt_q <= cfg_amt;
      end
    end
  end

  assign tx_valid   = ov_q;
  assign tx_is_addr = oa_q;
  assign tx_data    = od_q;
  assign busy       = (st_q != TX_IDLE);
  assign err        = err_q;
endmodule

// File: rtl/msg_dma_rx_chan.sv
module msg_dma_rx_chan #(
  parameter int DW  = 32,
  parameter int LAW = 8,
  parameter int CW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     off,
  input  logic [DW-1:0]  wr_data,
  input  logic           beat,
  input  logic [DW-1:0]  addr_word,
  output logic           hit,
  output logic           last,
  output logic [LAW-1:0] wr_addr,
  output logic           en,
  output logic           ie,
  output logic           done,
  output logic [DW-1:0]  rd_word
);
  logic [DW-1:0]  match_q, match_d;
  logic [LAW-1:0] base_q, base_d;
  logic [CW-1:0]  cnt_q, cnt_d, ptr_q, ptr_d;
  logic           en_q, en_d, ie_q, ie_d, done_q, done_d;

  assign hit     = en_q && (addr_word == match_q);
  assign last    = ((ptr_q + CW'(1)) == cnt_q);
  assign wr_addr = base_q + LAW'(ptr_q);

  always_comb begin
    match_d = match_q; base_d = base_q; cnt_d = cnt_q; ptr_d = ptr_q;
    en_d = en_q; ie_d = ie_q; done_d = done_q;
    if (beat) begin
      ptr_d = ptr_q + CW'(1);
      if (last) begin
        done_d = 1'b1; en_d = 1'b0;
      end
    end
    if (wr_en) begin
      unique case (off)
        2'd0: match_d = wr_data;
        2'd1: base_d  = wr_data[LAW-1:0];
        2'd2: cnt_d   = wr_data[CW-1:0];
        default: begin
          en_d = wr_data[0];
          ie_d = wr_data[1];
          if (wr_data[2]) done_d = 1'b0;
          if (wr_data[0]) ptr_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0; base_q <= '0; cnt_q <= '0; ptr_q <= '0;
      en_q <= 1'b0; ie_q <= 1'b0; done_q <= 1'b0;
    end else begin
      match_q <= match_d; base_q <= base_d; cnt_q <= cnt_d; ptr_q <= ptr_d;
      en_q <= en_d; ie_q <= ie_d; done_q <= done_d;
    end
  end

  always_comb begin
    unique case (off)
      2'd0:    rd_word = match_q;
      2'd1:    rd_word = DW'(base_q);
      2'd2:    rd_word = DW'(cnt_q);
      default: rd_word = DW'({done_q, ie_q, en_q});
    endcase
  end

  assign en   = en_q;
  assign ie   = ie_q;
  assign done = done_q;
endmodule

// File: rtl/msg_dma_engine.sv
module msg_dma_engine
  import msg_dma_pkg::*;
#(
  parameter int DW     = 32,
  parameter int LAW    = 8,
  parameter int CW     = 8,
  parameter int NRX    = 4,
  parameter int CFG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  output logic              tx_valid,
  output logic              tx_is_addr,
  output logic [DW-1:0]     tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic              rx_is_addr,
  input  logic [DW-1:0]     rx_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [LAW-1:0]    mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic              irq
);
  localparam int CHW = (NRX > 1) ? $clog2(NRX) : 1;

  logic [LAW-1:0] src_q;
  logic [DW-1:0]  dst_q;
  logic [CW-1:0]  amt_q;
  logic           gsel, ctl_wr, tx_start, tx_busy, tx_err, tx_rd_req;
  logic [LAW-1:0] tx_rd_addr;
  logic           act_q, act_d, unm_q, unm_d, any_hit, rx_wr;
  logic [CHW-1:0] ch_q, ch_d, first;
  logic [NRX-1:0] ch_sel, ch_hit, ch_last, ch_en, ch_ie, ch_done, beat;
  logic [LAW-1:0] ch_waddr [NRX];
  logic [DW-1:0]  ch_rd    [NRX];

  assign gsel     = cfg_addr < CFG_AW'(CH_BASE);
  assign ctl_wr   = cfg_we && (cfg_addr == CFG_AW'(REG_CTL));
  assign tx_start = ctl_wr && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; amt_q <= '0;
    end else begin
      if (cfg_we && cfg_addr == CFG_AW'(REG_SRC)) src_q <= cfg_wdata[LAW-1:0];
      if (cfg_we && cfg_addr == CFG_AW'(REG_DST)) dst_q <= cfg_wdata;
      if (cfg_we && cfg_addr == CFG_AW'(REG_AMT)) amt_q <= cfg_wdata[CW-1:0];
    end
  end

  msg_dma_tx #(.DW(DW), .LAW(LAW), .CW(CW)) u_tx (
    .clk, .rst_n, .start(tx_start), .err_clr(ctl_wr && cfg_wdata[1]),
    .cfg_src(src_q), .cfg_dst(dst_q), .cfg_amt(amt_q),
    .mem_gnt(!rx_wr), .mem_rdata, .rd_req(tx_rd_req), .rd_addr(tx_rd_addr),
    .tx_valid, .tx_is_addr, .tx_data, .tx_ready, .busy(tx_busy), .err(tx_err)
  );

  for (genvar i = 0; i < NRX; i++) begin : g_ch
    localparam logic [CFG_AW-3:0] SLOT = (CFG_AW-2)'(CH_BASE/4 + i);
    assign ch_sel[i] = (cfg_addr[CFG_AW-1:2] == SLOT);
    assign beat[i]   = rx_valid && !rx_is_addr && act_q && (ch_q == CHW'(i)) && ch_en[i];
    msg_dma_rx_chan #(.DW(DW), .LAW(LAW), .CW(CW)) u_ch (
      .clk, .rst_n, .wr_en(cfg_we && ch_sel[i]), .off(cfg_addr[1:0]),
      .wr_data(cfg_wdata), .beat(beat[i]), .addr_word(rx_data),
      .hit(ch_hit[i]), .last(ch_last[i]), .wr_addr(ch_waddr[i]),
      .en(ch_en[i]), .ie(ch_ie[i]), .done(ch_done[i]), .rd_word(ch_rd[i])
    );
  end

  // lowest index wins among matching channels
  always_comb begin
    any_hit = 1'b0;
    first   = '0;
    for (int i = NRX - 1; i >= 0; i--) begin
      if (ch_hit[i]) begin
        any_hit = 1'b1;
        first   = CHW'(i);
      end
    end
  end

  assign rx_wr = |beat;

  always_comb begin
    act_d = act_q; ch_d = ch_q; unm_d = unm_q;
    if (ctl_wr && cfg_wdata[2]) unm_d = 1'b0;
    if (rx_valid && rx_is_addr) begin
      if (any_hit) begin
        act_d = 1'b1; ch_d = first;
      end else begin
        act_d = 1'b0; unm_d = 1'b1;
      end
    end else if (rx_wr && ch_last[ch_q]) begin
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; ch_q <= '0; unm_q <= 1'b0;
    end else begin
      act_q <= act_d; ch_q <= ch_d; unm_q <= unm_d;
    end
  end

  // receive writes own the port; transmit reads take free cycles
  assign mem_en    = rx_wr || tx_rd_req;
  assign mem_we    = rx_wr;
  assign mem_addr  = rx_wr ? ch_waddr[ch_q] : tx_rd_addr;
  assign mem_wdata = rx_data;
  assign irq       = |(ch_done & ch_ie);

  always_comb begin
    cfg_rdata = '0;
    if (gsel) begin
      unique case (cfg_addr[2:0])
        3'(REG_SRC): cfg_rdata = DW'(src_q);
        3'(REG_DST): cfg_rdata = dst_q;
        3'(REG_AMT): cfg_rdata = DW'(amt_q);
        3'(REG_CTL): cfg_rdata = DW'({unm_q, tx_err, tx_busy});
        default:     cfg_rdata = '0;
      endcase
    end else begin
      for (int i = 0; i < NRX; i++) begin
        if (ch_sel[i]) cfg_rdata = ch_rd[i];
      end
    end
  end
endmodule

// File: rtl/msg_dma_chk.sv
module msg_dma_chk #(
  parameter int DW  = 32,
  parameter int NRX = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tx_valid,
  input logic           tx_ready,
  input logic           tx_is_addr,
  input logic [DW-1:0]  tx_data,
  input logic           tx_busy,
  input logic           tx_err,
  input logic           tx_start,
  input logic           irq,
  input logic [NRX-1:0] ch_done,
  input logic [NRX-1:0] ch_en
);
  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_is_addr));

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy && tx_start |=> tx_err);

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !tx_valid);

  // R2
  single_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_is_addr |=> !(tx_valid && tx_is_addr));

  // R7
  done_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_done & ~$past(ch_done) & ch_en) == '0);

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ch_done != '0));
endmodule

bind msg_dma_engine msg_dma_chk #(.DW(DW), .NRX(NRX)) i_chk (.*);

// File: tb/test_msg_dma_engine.sv
module test_msg_dma_engine;
  logic        clk, rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        tx_valid, tx_is_addr, tx_ready;
  logic [31:0] tx_data;
  logic        rx_valid, rx_is_addr;
  logic [31:0] rx_data;
  logic        mem_en, mem_we, irq;
  logic [7:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int stall_mode = 0;
  int cap_n  = 0;
  int vcnt   = 0;
  int wr_cnt = 0;
  logic [31:0] cap_d [256];
  logic        cap_a [256];
  logic [31:0] ram   [256];

  msg_dma_engine i_msg_dma_engine (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .tx_valid, .tx_is_addr, .tx_data, .tx_ready,
    .rx_valid, .rx_is_addr, .rx_data,
    .mem_en, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .irq
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] pat(input logic [7:0] a);
    return 32'h5A00_0000 | {16'h0, a, ~a};
  endfunction

  // low half is a read-only pattern, high half is writable
  assign mem_rdata = mem_addr[7] ? ram[mem_addr] : pat(mem_addr);
  always @(posedge clk) begin
    if (mem_en && mem_we) begin
      ram[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  // bus sink: choose ready, then log the handshake of the coming edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    case (stall_mode)
      1:       tx_ready = cyc[0];
      2:       tx_ready = (cyc % 3 == 0);
      default: tx_ready = 1'b1;
    endcase
    if (tx_valid) vcnt = vcnt + 1;
    if (tx_valid && tx_ready) begin
      cap_d[cap_n[7:0]] = tx_data;
      cap_a[cap_n[7:0]] = tx_is_addr;
      cap_n = cap_n + 1;
    end
  end

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [4:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [4:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic rx_beat(input logic is_a, input logic [31:0] d);
    rx_valid = 1'b1; rx_is_addr = is_a; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0; rx_is_addr = 1'b0;
  endtask

  task automatic wait_idle;
    logic [31:0] s;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      cfg_rd(5'd3, s);
      if (!s[0]) return;
    end
    chk("R2 burst never finished", 32'd1, 32'd0);
  endtask

  // {src, amount, stall mode, target tag}
  localparam logic [31:0] TXV [4] = '{
    {8'h00, 8'd1, 8'd0, 8'h11},
    {8'h10, 8'd5, 8'd1, 8'h22},
    {8'h20, 8'd8, 8'd2, 8'h33},
    {8'h7C, 8'd3, 8'd1, 8'h44}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] s;
    int base, snap;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    rx_valid = 1'b0; rx_is_addr = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'd0);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 mem_en", {31'b0, mem_en}, 32'd0);
    cfg_rd(5'd3, s); chk("R1 status", s, 32'd0);

    // R2/R3 vector table of bursts under several stall patterns
    for (int v = 0; v < 4; v++) begin
      logic [7:0] src, amt;
      logic [31:0] dst;
      src = TXV[v][31:24]; amt = TXV[v][23:16];
      dst = 32'hF000_0000 | {24'h0, TXV[v][7:0]};
      stall_mode = int'(TXV[v][15:8]);
      cfg_wr(5'd0, {24'h0, src});
      cfg_wr(5'd1, dst);
      cfg_wr(5'd2, {24'h0, amt});
      base = cap_n;
      cfg_wr(5'd3, 32'd1);
      wait_idle();
      chk("R2 word count", cap_n - base, 32'(amt) + 1);
      chk("R2 address flag", {31'b0, cap_a[base[7:0]]}, 32'd1);
      chk("R2 address word", cap_d[base[7:0]], dst);
      for (int k = 0; k < int'(amt); k++) begin
        chk("R2 R3 data word", cap_d[8'(base + 1 + k)], pat(src + 8'(k)));
        chk("R2 data flag", {31'b0, cap_a[8'(base + 1 + k)]}, 32'd0);
      end
    end

    // R4 start while busy is refused, running burst keeps its source
    stall_mode = 2;
    cfg_wr(5'd0, 32'h30);
    cfg_wr(5'd1, 32'hF000_0066);
    cfg_wr(5'd2, 32'd20);
    base = cap_n;
    cfg_wr(5'd3, 32'd1);
    cfg_wr(5'd0, 32'h50);
    cfg_wr(5'd3, 32'd1);
    cfg_rd(5'd3, s); chk("R4 busy and error", s & 32'h3, 32'h3);
    wait_idle();
    chk("R4 word count", cap_n - base, 32'd21);
    chk("R4 first data from original source", cap_d[8'(base + 1)], pat(8'h30));
    chk("R4 last data", cap_d[8'(base + 20)], pat(8'h30 + 8'd19));
    cfg_wr(5'd3, 32'h2);
    cfg_rd(5'd3, s); chk("R4 error cleared", s, 32'd0);

    // R5 zero count
    stall_mode = 0;
    cfg_wr(5'd2, 32'd0);
    snap = vcnt;
    cfg_wr(5'd3, 32'd1);
    repeat (4) @(negedge clk);
    cfg_rd(5'd3, s); chk("R5 error set, not busy", s, 32'h2);
    chk("R5 no bus word", vcnt - snap, 32'd0);
    cfg_wr(5'd3, 32'h2);

    // R6 R7 R9 interleaved receive streams
    cfg_wr(5'd8, 32'hA000_0001); cfg_wr(5'd9, 32'h80); cfg_wr(5'd10, 32'd3); cfg_wr(5'd11, 32'h3);
    cfg_wr(5'd12, 32'hA000_0002); cfg_wr(5'd13, 32'h90); cfg_wr(5'd14, 32'd2); cfg_wr(5'd15, 32'h1);
    snap = wr_cnt;
    rx_beat(1'b1, 32'hA000_0001); rx_beat(1'b0, 32'h1111_0000);
    rx_beat(1'b1, 32'hA000_0002); rx_beat(1'b0, 32'h2222_0000);
    rx_beat(1'b1, 32'hA000_0001); rx_beat(1'b0, 32'h1111_0001);
    rx_beat(1'b1, 32'hA000_0002); rx_beat(1'b0, 32'h2222_0001);
    chk("R9 done without irq enable gives no irq", {31'b0, irq}, 32'd0);
    rx_beat(1'b1, 32'hA000_0001); rx_beat(1'b0, 32'h1111_0002);
    rx_beat(1'b0, 32'h1111_0003);
    chk("R6 ch0 word0", ram[8'h80], 32'h1111_0000);
    chk("R6 ch0 word1", ram[8'h81], 32'h1111_0001);
    chk("R6 ch0 word2", ram[8'h82], 32'h1111_0002);
    chk("R6 ch1 word0", ram[8'h90], 32'h2222_0000);
    chk("R6 ch1 word1", ram[8'h91], 32'h2222_0001);
    chk("R7 extra word dropped", 32'(wr_cnt - snap), 32'd5);
    cfg_rd(5'd11, s); chk("R7 ch0 done, disarmed", s, 32'h6);
    cfg_rd(5'd15, s); chk("R7 ch1 done, disarmed", s, 32'h4);
    chk("R9 irq raised", {31'b0, irq}, 32'd1);
    cfg_wr(5'd11, 32'h4);
    chk("R9 irq after done cleared", {31'b0, irq}, 32'd0);
    cfg_rd(5'd11, s); chk("R9 ch0 control after clear", s, 32'd0);

    // R8 unmatched address
    snap = wr_cnt;
    rx_beat(1'b1, 32'hA000_0002); rx_beat(1'b0, 32'h7777_0000); rx_beat(1'b0, 32'h7777_0001);
    cfg_rd(5'd3, s); chk("R8 unmatched flag", s, 32'h4);
    chk("R8 no memory write", 32'(wr_cnt - snap), 32'd0);
    cfg_wr(5'd3, 32'h4);
    cfg_rd(5'd3, s); chk("R8 flag cleared", s, 32'd0);

    // R11 same match address on two channels
    cfg_wr(5'd16, 32'hA000_0005); cfg_wr(5'd17, 32'hA0); cfg_wr(5'd18, 32'd1); cfg_wr(5'd19, 32'h1);
    cfg_wr(5'd20, 32'hA000_0005); cfg_wr(5'd21, 32'hB0); cfg_wr(5'd22, 32'd1); cfg_wr(5'd23, 32'h1);
    rx_beat(1'b1, 32'hA000_0005); rx_beat(1'b0, 32'h3333_0000);
    chk("R11 lower channel buffer", ram[8'hA0], 32'h3333_0000);
    cfg_rd(5'd19, s); chk("R11 ch2 done", s, 32'h4);
    cfg_rd(5'd23, s); chk("R11 ch3 untouched", s, 32'h1);

    // R10 receive writes collide with transmit reads
    cfg_wr(5'd9, 32'hC0); cfg_wr(5'd10, 32'd6); cfg_wr(5'd11, 32'h1);
    stall_mode = 0;
    cfg_wr(5'd0, 32'h40); cfg_wr(5'd1, 32'hF000_0055); cfg_wr(5'd2, 32'd6);
    base = cap_n;
    cfg_wr(5'd3, 32'd1);
    rx_beat(1'b1, 32'hA000_0001);
    for (int k = 0; k < 6; k++) rx_beat(1'b0, 32'h4444_0000 + 32'(k));
    wait_idle();
    chk("R10 tx word count", cap_n - base, 32'd7);
    chk("R10 tx address word", cap_d[base[7:0]], 32'hF000_0055);
    for (int k = 0; k < 6; k++) begin
      chk("R10 tx data", cap_d[8'(base + 1 + k)], pat(8'h40 + 8'(k)));
      chk("R10 rx data", ram[8'hC0 + 8'(k)], 32'h4444_0000 + 32'(k));
    end
    cfg_rd(5'd11, s); chk("R10 rx channel done", s, 32'h4);

    report();
  end
endmodule